// File: doc/BRIEF.md
# I2C Controller Command Sequencer

This block runs the controller side of I2C transfers. Software, or an upstream queue, feeds it 13-bit format words over a valid/ready port. Each word may open the bus with a START, or with a repeated START if the bus is already held. It then either sends one byte and samples the target's acknowledge, or reads a programmed number of bytes. It may close the bus with a STOP afterwards. Received bytes leave through an RX valid/ready port. SCL and SDA are driven as open-drain enables, so a 1 on an enable pulls the line low. SDA is sampled from the pad.

A write byte that the target refuses stops the sequencer unless the word allows a refusal. The sequencer then keeps the bus parked: SCL is held low, SDA is released and no STOP is sent. It stays there until software clears the latched reason. An optional watchdog counts the parked cycles and, if no clear arrives, closes the bus with a STOP and latches a second reason. Every SCL high and low segment lasts `half_cnt` clock cycles.

Back-pressure: a word is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only between words while nothing is halted. The RX port does not wait. `rx_valid` is a single-cycle strobe, and a byte offered while `rx_ready` is low is lost and noted in `rx_overflow`.

Top module: `i2c_cmd_seq`

## Requirements
- R1: `cmd_ready` is high only when the sequencer is between words and `halted` is low. A word offered while halted is not consumed and causes no bus activity.
- R2: Word bit 8 requests a START before the byte: a plain START if the bus is free, otherwise a repeated START. Bit 9 requests a STOP after the byte, and the bus is released (both enables low) after the STOP.
- R3: With bit 10 clear, bits 7:0 are sent MSB first, followed by a ninth clock in which SDA is released and the target's acknowledge is sampled (low = ACK).
- R4: With bit 10 set, bits 7:0 give the number of bytes to read, and 0 means 256. Each byte is assembled MSB first and offered on `rx_data` with a one-cycle `rx_valid`.
- R5: After every read byte but the last, the controller drives ACK. After the last it releases SDA (NACK), unless bit 11 is set, in which case it drives ACK and the bus stays open for the next word.
- R6: Each SCL high phase of a data or acknowledge bit lasts exactly `half_cnt` cycles, SDA changes only while SCL is low except at START and STOP, and SDA is sampled in the middle of the high phase.
- R7: A refused write byte with bit 12 clear sets `evt_nack` and parks the bus with SCL held low, SDA released and no STOP. With bit 12 set the sequencer carries on as if acknowledged.
- R8: `halted` is high while `evt_nack` or `evt_timeout` is set. A 1 on `evt_clr[0]` clears `evt_nack` and `evt_clr[1]` clears `evt_timeout`, and the sequencer resumes accepting words once both are clear.
- R9: With `nack_to_en` high, a park that lasts `nack_to_cyc` cycles without a clear ends with a STOP. `evt_timeout` is then set and the bus becomes free. With `nack_to_en` low the park lasts indefinitely.
- R10: `cmd_done` pulses for one cycle for every repeated START and every STOP, and not for a START on a free bus.
- R11: A read byte completing while `rx_ready` is low is dropped and `rx_overflow` becomes set and stays set until reset.
- R12: `idle` is high exactly when no transfer holds the bus, the sequencer is between words and `cmd_valid` is low.
- R13: After reset both enables are low, `idle` and `cmd_ready` are high, and all event and overflow flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_cnt | input | CNT_W | Cycles per SCL segment, at least 2 |
| cmd_valid | input | 1 | Format word valid |
| cmd_ready | output | 1 | Format word accepted this cycle when valid |
| cmd_word | input | 13 | Format word: byte 7:0, START 8, STOP 9, read 10, read-continue 11, refusal-allowed 12 |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_ready | input | 1 | Receiver can take the byte |
| rx_data | output | 8 | Received byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |
| nack_to_en | input | 1 | Enable the parked-bus watchdog |
| nack_to_cyc | input | TO_W | Watchdog length in cycles |
| evt_clr | input | 2 | Write-1-to-clear for the two events |
| evt_nack | output | 1 | Latched refused-write event |
| evt_timeout | output | 1 | Latched watchdog-STOP event |
| halted | output | 1 | Any event latched |
| cmd_done | output | 1 | Pulse on repeated START or STOP |
| rx_overflow | output | 1 | Sticky dropped-byte flag |
| idle | output | 1 | Bus free, no word pending |

## Verification
The properties assume that `half_cnt` stays at 2 or more and does not change during a transfer. They also assume that `sda_in` reflects a line that only the controller and a well-behaved target pull. In particular, the target never holds SDA low across a repeated START or STOP. The bench keeps `half_cnt` constant and models an open-drain target that changes SDA one cycle after SCL falls. That target releases the line once the controller refuses a read byte, and it is never asked to read across a repeated START. A refusal is only requested on write bytes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int FMT_W = 13;

  // Field positions of a format word; decoded by the sequencer.
  typedef struct packed {
    logic       nakok;   // bit 12
    logic       rcont;   // bit 11
    logic       rd;      // bit 10
    logic       stop;    // bit 9
    logic       start;   // bit 8
    logic [7:0] data;    // bits 7:0
  } fmt_word_t;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_STOP   = 2'd2,
    OP_BIT    = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_STA    = 4'd1,
    ST_STA_W  = 4'd2,
    ST_DBIT   = 4'd3,
    ST_DBIT_W = 4'd4,
    ST_ABIT   = 4'd5,
    ST_ABIT_W = 4'd6,
    ST_STO    = 4'd7,
    ST_STO_W  = 4'd8,
    ST_HALT   = 4'd9
  } seq_state_e;

endpackage

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_cnt,
  input  logic             op_valid,
  input  bus_op_e          op,
  input  logic             op_bit,
  input  logic             sda_in,
  output logic             op_ready,
  output logic             op_done,
  output logic             rx_bit,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy;
  bus_op_e          cur_op;
  logic             cur_bit;
  logic [1:0]       seg;
  logic [CNT_W-1:0] cnt;
  logic             seg_end;
  logic             mid_high;
  logic [1:0]       drv_first;
  logic [1:0]       drv_next;

  // Segment table: returns {pull SCL low, pull SDA low}.
  function automatic logic [1:0] seg_drive(bus_op_e o, logic [1:0] s, logic b);
    logic [1:0] r;
    case (o)
      OP_START:  r = (s == 2'd0) ? 2'b01 : 2'b11;
      OP_RSTART: begin
        case (s)
          2'd0:    r = 2'b10;
          2'd1:    r = 2'b00;
          2'd2:    r = 2'b01;
          default: r = 2'b11;
        endcase
      end
      OP_STOP: begin
        case (s)
          2'd0:    r = 2'b11;
          2'd1:    r = 2'b01;
          default: r = 2'b00;
        endcase
      end
      default:   r = {(s == 2'd0), ~b};
    endcase
    return r;
  endfunction

  function automatic logic [1:0] seg_last(bus_op_e o);
    logic [1:0] r;
    case (o)
      OP_START:  r = 2'd1;
      OP_RSTART: r = 2'd3;
      OP_STOP:   r = 2'd2;
      default:   r = 2'd1;
    endcase
    return r;
  endfunction

  assign op_ready  = ~busy;
  assign seg_end   = busy && (cnt == half_cnt - ONE);
  assign mid_high  = busy && (cur_op == OP_BIT) && (seg == 2'd1) && (cnt == (half_cnt >> 1));
  assign drv_first = seg_drive(op, 2'd0, op_bit);
  assign drv_next  = seg_drive(cur_op, seg + 2'd1, cur_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_op  <= OP_STOP;
      cur_bit <= 1'b1;
      seg     <= 2'd0;
      cnt     <= '0;
      op_done <= 1'b0;
      rx_bit  <= 1'b1;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (!busy) begin
        if (op_valid) begin
          busy             <= 1'b1;
          cur_op           <= op;
          cur_bit          <= op_bit;
          seg              <= 2'd0;
          cnt              <= '0;
          {scl_oe, sda_oe} <= drv_first;
        end
      end else begin
        if (mid_high) rx_bit <= sda_in;
        if (seg_end) begin
          if (seg == seg_last(cur_op)) begin
            busy    <= 1'b0;
            op_done <= 1'b1;
            // Rest state: SCL stays low inside a transfer, free after STOP.
            scl_oe  <= (cur_op != OP_STOP);
          end else begin
            seg              <= seg + 2'd1;
            cnt              <= '0;
            {scl_oe, sda_oe} <= drv_next;
          end
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_halt_timer.sv
module i2c_halt_timer #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         fire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + W'(1);
    end
  end

  assign fire = run && en && (cnt == limit);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TO_W  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_cnt,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [12:0]      cmd_word,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in,
  input  logic             nack_to_en,
  input  logic [TO_W-1:0]  nack_to_cyc,
  input  logic [1:0]       evt_clr,
  output logic             evt_nack,
  output logic             evt_timeout,
  output logic             halted,
  output logic             cmd_done,
  output logic             rx_overflow,
  output logic             idle
);

  localparam int          BYTE_W  = 8;
  localparam int          RD_W    = $clog2(1 << BYTE_W) + 1;
  localparam logic [RD_W-1:0] RD_FULL = RD_W'(1 << BYTE_W);
  localparam logic [RD_W-1:0] RD_ONE  = RD_W'(1);

  seq_state_e       state;
  fmt_word_t        cur;
  fmt_word_t        in_word;
  logic [BYTE_W-1:0] sh;
  logic [2:0]       bidx;
  logic [RD_W-1:0]  rem;
  logic             active;
  logic             to_stop;

  logic             eng_valid;
  logic             eng_ready;
  bus_op_e          eng_op;
  logic             eng_bit;
  logic             eng_done;
  logic             eng_rx;
  logic             accept;
  logic             last_rd;
  logic             to_fire;
  logic             take;

  assign in_word   = fmt_word_t'(cmd_word);
  assign halted    = evt_nack | evt_timeout;
  assign cmd_ready = (state == ST_IDLE) && !halted;
  assign take      = cmd_valid && cmd_ready;
  assign idle      = (state == ST_IDLE) && !active && !cmd_valid;
  assign last_rd   = (rem == RD_ONE);

  // Bus primitive requested by the current state.
  always_comb begin
    eng_valid = 1'b0;
    eng_op    = OP_BIT;
    eng_bit   = 1'b1;
    case (state)
      ST_STA: begin
        eng_valid = 1'b1;
        eng_op    = active ? OP_RSTART : OP_START;
      end
      ST_DBIT: begin
        eng_valid = 1'b1;
        eng_bit   = cur.rd ? 1'b1 : sh[BYTE_W-1];
      end
      ST_ABIT: begin
        eng_valid = 1'b1;
        eng_bit   = cur.rd ? (last_rd && !cur.rcont) : 1'b1;
      end
      ST_STO: begin
        eng_valid = 1'b1;
        eng_op    = OP_STOP;
      end
      default: ;
    endcase
  end

  assign accept = eng_valid && eng_ready;

  i2c_bit_engine #(.CNT_W(CNT_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_cnt (half_cnt),
    .op_valid (eng_valid),
    .op       (eng_op),
    .op_bit   (eng_bit),
    .sda_in   (sda_in),
    .op_ready (eng_ready),
    .op_done  (eng_done),
    .rx_bit   (eng_rx),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );

  i2c_halt_timer #(.W(TO_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_HALT),
    .en    (nack_to_en),
    .limit (nack_to_cyc),
    .fire  (to_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur         <= '0;
      sh          <= '0;
      bidx        <= 3'd0;
      rem         <= '0;
      active      <= 1'b0;
      to_stop     <= 1'b0;
      evt_nack    <= 1'b0;
      evt_timeout <= 1'b0;
      cmd_done    <= 1'b0;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      rx_overflow <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      rx_valid <= 1'b0;

      if (rx_valid && !rx_ready) rx_overflow <= 1'b1;
      if (evt_clr[0]) evt_nack    <= 1'b0;
      if (evt_clr[1]) evt_timeout <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (take) begin
            cur   <= in_word;
            sh    <= in_word.data;
            bidx  <= 3'd0;
            rem   <= (in_word.data == '0) ? RD_FULL : {1'b0, in_word.data};
            state <= in_word.start ? ST_STA : ST_DBIT;
          end
        end
        ST_STA: begin
          if (accept) begin
            cmd_done <= active;
            active   <= 1'b1;
            state    <= ST_STA_W;
          end
        end
        ST_STA_W: if (eng_done) state <= ST_DBIT;
        ST_DBIT: if (accept) state <= ST_DBIT_W;
        ST_DBIT_W: begin
          if (eng_done) begin
            sh   <= {sh[BYTE_W-2:0], cur.rd ? eng_rx : 1'b0};
            bidx <= bidx + 3'd1;
            if (bidx == 3'd7) begin
              state <= ST_ABIT;
              if (cur.rd) begin
                rx_valid <= 1'b1;
                rx_data  <= {sh[BYTE_W-2:0], eng_rx};
              end
            end else begin
              state <= ST_DBIT;
            end
          end
        end
        ST_ABIT: if (accept) state <= ST_ABIT_W;
        ST_ABIT_W: begin
          if (eng_done) begin
            if (cur.rd) begin
              if (last_rd) begin
                state <= cur.stop ? ST_STO : ST_IDLE;
              end else begin
                rem   <= rem - RD_ONE;
                state <= ST_DBIT;
              end
            end else if (!eng_rx || cur.nakok) begin
              state <= cur.stop ? ST_STO : ST_IDLE;
            end else begin
              evt_nack <= 1'b1;
              state    <= ST_HALT;
            end
          end
        end
        ST_HALT: begin
          if (!evt_nack) begin
            state <= ST_IDLE;
          end else if (to_fire) begin
            to_stop <= 1'b1;
            state   <= ST_STO;
          end
        end
        ST_STO: begin
          if (accept) begin
            cmd_done <= 1'b1;
            state    <= ST_STO_W;
          end
        end
        ST_STO_W: begin
          if (eng_done) begin
            active <= 1'b0;
            state  <= ST_IDLE;
            if (to_stop) begin
              evt_timeout <= 1'b1;
              to_stop     <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic scl_oe,
  input logic sda_oe,
  input logic evt_nack,
  input logic evt_timeout,
  input logic halted,
  input logic rx_overflow,
  input logic idle,
  input logic cmd_done
);

  // R1
  ready_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !halted);

  // R7
  nack_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_nack) |-> (scl_oe && !sda_oe));

  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_timeout) |-> (!scl_oe && !sda_oe));

  // R11
  rx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_overflow);

  // R12
  idle_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!scl_oe && !sda_oe && !cmd_valid));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (.*);

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_cnt = 16'(HALF);
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [12:0] cmd_word = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [7:0]  rx_data;
  logic        scl_oe, sda_oe, sda_in;
  logic        nack_to_en = 1'b0;
  logic [30:0] nack_to_cyc = 31'd0;
  logic [1:0]  evt_clr = 2'b00;
  logic        evt_nack, evt_timeout, halted, cmd_done, rx_overflow, idle;

  logic tgt_low = 1'b0;
  logic tgt_read = 1'b0;
  logic tgt_nack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_in = !(sda_oe || tgt_low);
  wire scl_line = !scl_oe;

  i2c_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .half_cnt(half_cnt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
    .nack_to_en(nack_to_en), .nack_to_cyc(nack_to_cyc), .evt_clr(evt_clr),
    .evt_nack(evt_nack), .evt_timeout(evt_timeout), .halted(halted),
    .cmd_done(cmd_done), .rx_overflow(rx_overflow), .idle(idle)
  );

  function automatic logic [7:0] tdata(int k);
    return 8'((k * 29 + 90) % 256);
  endfunction

  function automatic logic [12:0] mk(logic sta, logic sto, logic rd, logic rc, logic nk, logic [7:0] b);
    return {nk, rc, rd, sto, sta, b};
  endfunction

  // Target model and bus monitors, all at the falling clock edge.
  logic p_scl = 1'b1, p_sda = 1'b1, m_ack = 1'b1, in_hi = 1'b0;
  logic [7:0] tsh = '0, last_wr = '0;
  int bc = 0, tidx = 0, starts = 0, stops = 0, wcnt = 0, acks = 0, nacks = 0;
  int rx_total = 0, rx_bad = 0, done_cnt = 0, hi_len = 0, hi_ok = 0, hi_bad = 0;

  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin
      if (rx_data != tdata(rx_total)) rx_bad = rx_bad + 1;
      rx_total = rx_total + 1;
    end
    if (cmd_done) done_cnt = done_cnt + 1;

    if (p_scl && scl_line && p_sda && !sda_in) begin
      starts = starts + 1; bc = 0; tgt_low <= 1'b0; m_ack = 1'b1; in_hi = 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_in) begin
      stops = stops + 1; bc = 0; tgt_low <= 1'b0; m_ack = 1'b0; in_hi = 1'b0;
    end else if (!p_scl && scl_line) begin
      in_hi = 1'b1; hi_len = 1;
      if (bc < 8) tsh = {tsh[6:0], sda_in};
      else if (tgt_read) begin
        if (!sda_in) acks = acks + 1; else nacks = nacks + 1;
        m_ack = !sda_in;
      end
      bc = bc + 1;
    end else if (p_scl && !scl_line) begin
      if (in_hi) begin
        if (hi_len == HALF) hi_ok = hi_ok + 1; else hi_bad = hi_bad + 1;
      end
      in_hi = 1'b0;
      if (!tgt_read) begin
        if (bc == 8) begin
          last_wr = tsh; wcnt = wcnt + 1; tgt_low <= !tgt_nack;
        end else if (bc == 9) begin
          bc = 0; tgt_low <= 1'b0;
        end
      end else begin
        if (bc == 9) begin
          bc = 0; tidx = tidx + 1;
          tgt_low <= m_ack ? !tdata(tidx)[7] : 1'b0;
        end else if (bc == 8) tgt_low <= 1'b0;
        else if (m_ack) tgt_low <= !tdata(tidx)[7 - bc];
      end
    end else if (scl_line && in_hi) begin
      hi_len = hi_len + 1;
    end
    p_scl = scl_line;
    p_sda = sda_in;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks = checks + 1;
    if (act < lo || act > hi) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      report();
      $finish;
    end
  end

  task automatic handshake();
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [12:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    handshake();
  endtask

  task automatic settle();
    do @(negedge clk); while (!(cmd_ready || halted));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int s0, w0, d0, a0, n0, r0, b0, st0, wait_n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 idle", idle, 1);
    chk("R13 bus", {scl_oe, sda_oe}, 0);
    chk("R13 flags", {evt_nack, evt_timeout, halted, rx_overflow}, 0);
    chk("R13 ready", cmd_ready, 1);

    // R3 R2 R10 R12: write sweep
    for (int v = 0; v < 16; v++) begin
      logic [7:0] b;
      b = 8'(v * 17);
      s0 = stops; w0 = wcnt; d0 = done_cnt;
      send(mk(1, 1, 0, 0, 0, b));
      settle();
      chk("R3 write byte", last_wr, b);
      chk("R3 byte count", wcnt - w0, 1);
      chk("R2 stop seen", stops - s0, 1);
      chk("R10 stop pulse", done_cnt - d0, 1);
      chk("R12 idle after", idle, 1);
      chk("R8 not halted", halted, 0);
    end

    // R4 R5: read sweep, 0 means 256
    tgt_read = 1'b1;
    for (int i = 0; i < 5; i++) begin
      int n;
      n = (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 3 : (i == 3) ? 7 : 256;
      r0 = rx_total; b0 = rx_bad; a0 = acks; n0 = nacks;
      send(mk(1, 1, 1, 0, 0, 8'(n % 256)));
      settle();
      chk("R4 read count", rx_total - r0, n);
      chk("R4 read data", rx_bad - b0, 0);
      chk("R5 acks", acks - a0, n - 1);
      chk("R5 final nack", nacks - n0, 1);
    end
    chk("R11 no overflow", rx_overflow, 0);

    // R5 continued read across words
    r0 = rx_total; b0 = rx_bad; a0 = acks; n0 = nacks; s0 = stops; st0 = starts;
    send(mk(1, 0, 1, 1, 0, 8'd3));
    settle();
    chk("R12 open bus not idle", idle, 0);
    send(mk(0, 1, 1, 0, 0, 8'd2));
    settle();
    chk("R5 cont count", rx_total - r0, 5);
    chk("R5 cont data", rx_bad - b0, 0);
    chk("R5 cont acks", acks - a0, 4);
    chk("R5 cont nack", nacks - n0, 1);
    chk("R2 one start", starts - st0, 1);
    chk("R2 one stop", stops - s0, 1);
    tgt_read = 1'b0;

    // R2 R10 repeated start
    st0 = starts; s0 = stops; d0 = done_cnt; w0 = wcnt;
    send(mk(1, 0, 0, 0, 0, 8'hA3));
    settle();
    send(mk(1, 1, 0, 0, 0, 8'h5C));
    settle();
    chk("R2 two starts", starts - st0, 2);
    chk("R2 rstart stop", stops - s0, 1);
    chk("R10 rstart+stop pulses", done_cnt - d0, 2);
    chk("R3 rstart byte", last_wr, 8'h5C);
    chk("R3 rstart count", wcnt - w0, 2);

    // R7 refusal allowed
    tgt_nack = 1'b1;
    s0 = stops;
    send(mk(1, 1, 0, 0, 1, 8'h71));
    settle();
    chk("R7 nakok no halt", halted, 0);
    chk("R7 nakok stop", stops - s0, 1);

    // R7 R8 R1 park on refusal, watchdog off
    s0 = stops;
    send(mk(1, 0, 0, 0, 0, 8'h42));
    settle();
    repeat (200) @(negedge clk);
    chk("R7 evt_nack", evt_nack, 1);
    chk("R8 halted", halted, 1);
    chk("R7 no stop", stops - s0, 0);
    chk("R7 scl held", scl_oe, 1);
    chk("R7 sda free", sda_oe, 0);
    chk("R9 no timeout when off", evt_timeout, 0);
    tgt_nack = 1'b0;
    w0 = wcnt;
    cmd_word = mk(0, 1, 0, 0, 0, 8'h3C);
    cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 ready low", cmd_ready, 0);
    chk("R1 word ignored", wcnt - w0, 0);
    chk("R12 pending not idle", idle, 0);
    evt_clr = 2'b01;
    @(negedge clk);
    evt_clr = 2'b00;
    handshake();
    settle();
    chk("R8 resumed", halted, 0);
    chk("R8 byte after clear", last_wr, 8'h3C);
    chk("R8 stop after clear", stops - s0, 1);

    // R9 watchdog STOP
    nack_to_en = 1'b1;
    nack_to_cyc = 31'd60;
    tgt_nack = 1'b1;
    s0 = stops; d0 = done_cnt;
    send(mk(1, 0, 0, 0, 0, 8'h99));
    while (!halted) @(negedge clk);
    wait_n = 0;
    while (!evt_timeout) begin
      @(negedge clk);
      wait_n = wait_n + 1;
    end
    @(negedge clk);
    chk_rng("R9 delay", wait_n, 60, 60 + 3 * HALF + 10);
    chk("R9 stop issued", stops - s0, 1);
    chk("R10 timeout stop pulse", done_cnt - d0, 1);
    chk("R9 nack kept", evt_nack, 1);
    chk("R9 still halted", halted, 1);
    chk("R9 bus free", {scl_oe, sda_oe}, 0);
    chk("R12 idle after timeout", idle, 1);
    evt_clr = 2'b11;
    @(negedge clk);
    evt_clr = 2'b00;
    @(negedge clk);
    chk("R8 cleared", {halted, evt_nack, evt_timeout}, 0);
    tgt_nack = 1'b0;
    nack_to_en = 1'b0;

    // R6 bit timing
    chk("R6 high phases", hi_bad, 0);
    chk("R6 some phases", (hi_ok > 100) ? 1 : 0, 1);

    // R11 dropped bytes
    tgt_read = 1'b1;
    rx_ready = 1'b0;
    r0 = rx_total;
    send(mk(1, 1, 1, 0, 0, 8'd2));
    settle();
    chk("R11 overflow set", rx_overflow, 1);
    chk("R11 none taken", rx_total - r0, 0);
    rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 sticky", rx_overflow, 1);

    report();
    $finish;
  end

endmodule